// File: doc/BRIEF.md
# Hybrid Latch-Up Protection Controller

This block supervises a group of front-end hybrid channels that share one readout path. Each channel has a digital latch-up flag coming in and a power-enable line going out. A latch-up flag, once it has passed a two-flop synchroniser, turns that channel's power off. The flag is then held in a sticky fault state. From that point the channel receives no control signals, and its slot in the shared readout is filled with a fixed placeholder word. The readout downstream therefore keeps the same number of slots, in the same order and with the same timing, whatever channels are faulted.

A remote host switches single channels on and off through a small command port. It reads the power, fault and bypass state of every channel through a serial status register. The host captures a snapshot into that register and shifts it out one bit per clock, least significant bit first. A readout run starts with a single pulse. It walks the channels in ascending index order and spends a fixed number of cycles on each channel. During a channel's slot a per-channel read strobe is raised, but only when that channel is live.

Top module: `hyb_latchup_guard`

## Requirements
- R1: After reset, every power enable is 0, no channel is latched, every channel counts as bypassed, every control output and read strobe is 0, and no readout word is valid.
- R2: A command with `cmd_valid_i` high acts at the next clock edge, and only on channel `cmd_ch_i`. Op 2'b01 turns the channel on and op 2'b10 turns it off. Ops 2'b00 and 2'b11 have no effect.
- R3: When a latch-up flag is raised, the channel's power enable drops on the third rising edge and not before. It stays low, and the channel stays latched, after the flag falls. No other channel is affected.
- R4: A latched channel clears only when it receives an enable command while its synchronised flag is low. An enable sent while the flag is still high leaves the channel latched and off. A disable command leaves it latched.
- R5: A channel counts as bypassed when it is latched or powered off. Its slice of `hyb_ctl_o` (bits 3i+2..3i at the default width) is then all zeros. Otherwise the slice equals `hyb_ctl_i`.
- R6: A `rd_start_i` pulse while idle starts a run of 16 slots, numbered 0 to 15 in ascending order, each SLOT_LEN (default 2) cycles long. `rd_valid_o` is high for exactly the last cycle of each slot. `rd_sel_o` is one-hot on the live channel of the current slot. A `rd_start_i` during a run is ignored.
- R7: A bypassed channel's slot still produces its valid cycle, at the usual time. It presents the placeholder word 10'h200 instead of the channel's data, and its read strobe stays low.
- R8: A capture strobe loads the 48-bit status into the serial register. Channel i sits at bits 3i (power on), 3i+1 (latched) and 3i+2 (bypassed). Each shift cycle moves the register one place toward bit 0, and `scan_in_i` enters at bit 47. `scan_out_o` always shows bit 0. Capture takes priority over shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latchup_i | input | 16 | Per-channel latch-up flags, asynchronous |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_op_i | input | 2 | Command op: 01 enable, 10 disable |
| cmd_ch_i | input | 4 | Target channel of the command |
| pwr_en_o | output | 16 | Per-channel power enables |
| hyb_ctl_i | input | 3 | Control bundle broadcast toward the hybrids |
| hyb_ctl_o | output | 48 | Gated control bundle, 3 bits per channel |
| rd_start_i | input | 1 | Starts a readout run |
| hyb_data_i | input | 160 | Per-channel readout words, 10 bits each |
| rd_sel_o | output | 16 | Per-channel read strobes |
| rd_valid_o | output | 1 | Readout word valid |
| rd_slot_o | output | 4 | Slot index of the current word |
| rd_data_o | output | 10 | Readout word or placeholder |
| scan_capture_i | input | 1 | Load status snapshot |
| scan_shift_i | input | 1 | Shift status register one place |
| scan_in_i | input | 1 | Serial input at the top bit |
| scan_out_o | output | 1 | Serial output from bit 0 |

## Verification
Assertions check the following on every cycle:
- the channel's power drops on the edge after its synchronised flag rises;
- a channel never holds power while latched;
- a latched channel stays latched unless it is re-enabled;
- no control bits reach a bypassed channel;
- at most one read strobe is high;
- a run never stops early or restarts;
- the serial register shifts correctly.

Only the bench scenarios show the rest:
- the exact three-edge latency of the latch-up path;
- that a flag still held high defeats a re-enable;
- that every run yields sixteen valid words in ascending order with placeholders in the right slots;
- that the captured 48-bit image matches the per-channel state bit by bit.

// File: rtl/lup_pkg.sv
package lup_pkg;

  typedef enum logic [1:0] {
    OP_NOP     = 2'b00,
    OP_ENABLE  = 2'b01,
    OP_DISABLE = 2'b10,
    OP_RSVD    = 2'b11
  } cmd_op_e;

  // Per-channel status image, power bit at the lowest position.
  typedef struct packed {
    logic byp;
    logic lat;
    logic pwr;
  } ch_stat_t;

  localparam int unsigned STAT_BITS = $bits(ch_stat_t);

endpackage

// File: rtl/lup_sync.sv
module lup_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/lup_chan_ctrl.sv
module lup_chan_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic lu_s_i,
  input  logic en_cmd_i,
  input  logic dis_cmd_i,
  output logic pwr_o,
  output logic lat_o
);

  logic pwr_q, pwr_d;
  logic lat_q, lat_d;

  always_comb begin
    lat_d = lat_q;
    pwr_d = pwr_q;
    if (en_cmd_i) begin
      lat_d = 1'b0;
      pwr_d = 1'b1;
    end
    if (dis_cmd_i) pwr_d = 1'b0;
    // fault wins over any command in the same cycle
    if (lu_s_i) begin
      lat_d = 1'b1;
      pwr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      pwr_q <= pwr_d;
      lat_q <= lat_d;
    end
  end

  assign pwr_o = pwr_q;
  assign lat_o = lat_q;

  // R3
  fault_cuts_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lu_s_i |=> (!pwr_q && lat_q));

  // R3
  no_power_while_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_q && lat_q));

  // R4
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !en_cmd_i) |=> lat_q);

endmodule

// File: rtl/lup_readout_seq.sv
module lup_readout_seq #(
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned SLOT_LEN = 2,
  parameter int unsigned DW       = 10,
  parameter logic [DW-1:0] FILL   = 10'h200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [NUM_CH-1:0]    byp_i,
  input  logic [NUM_CH*DW-1:0] data_i,
  output logic [NUM_CH-1:0]    rd_sel_o,
  output logic                 valid_o,
  output logic [$clog2(NUM_CH)-1:0] slot_o,
  output logic [DW-1:0]        data_o
);

  localparam int unsigned CHW = $clog2(NUM_CH);
  localparam int unsigned CW  = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam logic [CHW-1:0] LAST_SLOT = CHW'(NUM_CH - 1);
  localparam logic [CW-1:0]  LAST_CNT  = CW'(SLOT_LEN - 1);

  logic           busy_q, busy_d;
  logic [CHW-1:0] slot_q, slot_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_last;

  assign cnt_last = (cnt_q == LAST_CNT);

  always_comb begin
    busy_d = busy_q;
    slot_d = slot_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        slot_d = '0;
        cnt_d  = '0;
      end
    end else if (cnt_last) begin
      cnt_d = '0;
      if (slot_q == LAST_SLOT) busy_d = 1'b0;
      else                     slot_d = slot_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      rd_sel_o[k] = busy_q && (slot_q == CHW'(k)) && !byp_i[k];
    end
  end

  assign valid_o = busy_q && cnt_last;
  assign slot_o  = slot_q;
  assign data_o  = byp_i[slot_q] ? FILL : data_i[slot_q*DW +: DW];

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel_o));

  // R6
  run_not_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(valid_o && slot_q == LAST_SLOT)) |=> busy_q);

  // R6
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && slot_q != LAST_SLOT) |=> (slot_q == CHW'($past(slot_q) + 1'b1)));

  // R7
  bypass_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && byp_i[slot_q]) |-> (rd_sel_o == '0));

endmodule

// File: rtl/lup_scan_status.sv
module lup_scan_status #(
  parameter int unsigned WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             sin_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             sout_o
);

  logic [WIDTH-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (capture_i)    sr_d = par_i;
    else if (shift_i) sr_d = {sin_i, sr_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sout_o = sr_q[0];

  // R8
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !capture_i) |=> (sr_q[WIDTH-2:0] == $past(sr_q[WIDTH-1:1])));

  // R8
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> (sr_q == $past(par_i)));

endmodule

// File: rtl/hyb_latchup_guard.sv
module hyb_latchup_guard #(
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned CTLW     = 3,
  parameter int unsigned DW       = 10,
  parameter int unsigned SLOT_LEN = 2,
  parameter logic [DW-1:0] FILL   = 10'h200
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH-1:0]           latchup_i,
  input  logic                        cmd_valid_i,
  input  logic [1:0]                  cmd_op_i,
  input  logic [$clog2(NUM_CH)-1:0]   cmd_ch_i,
  output logic [NUM_CH-1:0]           pwr_en_o,
  input  logic [CTLW-1:0]             hyb_ctl_i,
  output logic [NUM_CH*CTLW-1:0]      hyb_ctl_o,
  input  logic                        rd_start_i,
  input  logic [NUM_CH*DW-1:0]        hyb_data_i,
  output logic [NUM_CH-1:0]           rd_sel_o,
  output logic                        rd_valid_o,
  output logic [$clog2(NUM_CH)-1:0]   rd_slot_o,
  output logic [DW-1:0]               rd_data_o,
  input  logic                        scan_capture_i,
  input  logic                        scan_shift_i,
  input  logic                        scan_in_i,
  output logic                        scan_out_o
);

  import lup_pkg::*;

  localparam int unsigned CHW = $clog2(NUM_CH);
  localparam int unsigned SW  = NUM_CH * STAT_BITS;

  // reset: asserted at once, released on the clock
  logic rst_m_q, rst_s_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  assign rst_core_n = rst_s_q;

  logic [NUM_CH-1:0] lu_s;
  logic [NUM_CH-1:0] pwr, lat, byp;
  logic [NUM_CH-1:0] en_cmd, dis_cmd;
  logic [SW-1:0]     stat_vec;

  lup_sync #(.WIDTH(NUM_CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (latchup_i),
    .q_o   (lu_s)
  );

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      en_cmd[k]  = cmd_valid_i && (cmd_ch_i == CHW'(k)) && (cmd_op_i == OP_ENABLE);
      dis_cmd[k] = cmd_valid_i && (cmd_ch_i == CHW'(k)) && (cmd_op_i == OP_DISABLE);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ch_stat_t st;

    lup_chan_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .lu_s_i    (lu_s[i]),
      .en_cmd_i  (en_cmd[i]),
      .dis_cmd_i (dis_cmd[i]),
      .pwr_o     (pwr[i]),
      .lat_o     (lat[i])
    );

    assign byp[i]   = lat[i] | ~pwr[i];
    assign st.pwr   = pwr[i];
    assign st.lat   = lat[i];
    assign st.byp   = byp[i];
    assign stat_vec[i*STAT_BITS +: STAT_BITS] = st;
    assign hyb_ctl_o[i*CTLW +: CTLW] = byp[i] ? '0 : hyb_ctl_i;

    // R5
    ctl_only_live_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      (hyb_ctl_o[i*CTLW +: CTLW] != '0) |-> (pwr_en_o[i] && !lat[i]));
  end

  assign pwr_en_o = pwr;

  lup_readout_seq #(
    .NUM_CH   (NUM_CH),
    .SLOT_LEN (SLOT_LEN),
    .DW       (DW),
    .FILL     (FILL)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start_i  (rd_start_i),
    .byp_i    (byp),
    .data_i   (hyb_data_i),
    .rd_sel_o (rd_sel_o),
    .valid_o  (rd_valid_o),
    .slot_o   (rd_slot_o),
    .data_o   (rd_data_o)
  );

  lup_scan_status #(.WIDTH(SW)) u_scan (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .capture_i (scan_capture_i),
    .shift_i   (scan_shift_i),
    .sin_i     (scan_in_i),
    .par_i     (stat_vec),
    .sout_o    (scan_out_o)
  );

  // R7
  fill_on_bypass_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_valid_o && !pwr_en_o[rd_slot_o]) |-> (rd_data_o == FILL));

endmodule

// File: tb/hyb_latchup_guard_test.sv
module hyb_latchup_guard_test;

  localparam int N      = 16;
  localparam int CHW    = 4;
  localparam int CTLW   = 3;
  localparam int DW     = 10;
  localparam int SL     = 2;
  localparam logic [DW-1:0] FILL = 10'h200;
  localparam logic [CTLW-1:0] CTL = 3'b101;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] latchup_i = '0;
  logic cmd_valid_i = 1'b0;
  logic [1:0] cmd_op_i = 2'b00;
  logic [CHW-1:0] cmd_ch_i = '0;
  logic [N-1:0] pwr_en_o;
  logic [CTLW-1:0] hyb_ctl_i = CTL;
  logic [N*CTLW-1:0] hyb_ctl_o;
  logic rd_start_i = 1'b0;
  logic [N*DW-1:0] hyb_data_i;
  logic [N-1:0] rd_sel_o;
  logic rd_valid_o;
  logic [CHW-1:0] rd_slot_o;
  logic [DW-1:0] rd_data_o;
  logic scan_capture_i = 1'b0;
  logic scan_shift_i = 1'b0;
  logic scan_in_i = 1'b0;
  logic scan_out_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [N-1:0] m_pwr, m_lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  hyb_latchup_guard uut (
    .clk(clk), .rst_n(rst_n), .latchup_i(latchup_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_ch_i(cmd_ch_i),
    .pwr_en_o(pwr_en_o), .hyb_ctl_i(hyb_ctl_i), .hyb_ctl_o(hyb_ctl_o),
    .rd_start_i(rd_start_i), .hyb_data_i(hyb_data_i), .rd_sel_o(rd_sel_o),
    .rd_valid_o(rd_valid_o), .rd_slot_o(rd_slot_o), .rd_data_o(rd_data_o),
    .scan_capture_i(scan_capture_i), .scan_shift_i(scan_shift_i),
    .scan_in_i(scan_in_i), .scan_out_o(scan_out_o)
  );

  function automatic logic [DW-1:0] chan_word(int i);
    return DW'((i * 53 + 7) % 1024);
  endfunction

  initial begin
    for (int i = 0; i < N; i++) hyb_data_i[i*DW +: DW] = chan_word(i);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_byp();
    return m_lat | ~m_pwr;
  endfunction

  task automatic check_state(input string req);
    logic [N*CTLW-1:0] exp_ctl;
    logic [N-1:0] b;
    b = m_byp();
    for (int i = 0; i < N; i++) exp_ctl[i*CTLW +: CTLW] = b[i] ? '0 : CTL;
    chk(pwr_en_o == m_pwr, req, "pwr_en_o", 64'(pwr_en_o), 64'(m_pwr));
    chk(hyb_ctl_o == exp_ctl, req, "hyb_ctl_o", 64'(hyb_ctl_o), 64'(exp_ctl));
  endtask

  task automatic send_cmd(input logic [1:0] op, input int ch);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_ch_i = CHW'(ch);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    if (op == 2'b01 && !latchup_i[ch]) begin m_pwr[ch] = 1'b1; m_lat[ch] = 1'b0; end
    if (op == 2'b10) m_pwr[ch] = 1'b0;
  endtask

  task automatic scan_check(input string req);
    logic [3*N-1:0] exp_img;
    logic [N-1:0] b;
    int bad;
    logic [3*N-1:0] got;
    b = m_byp();
    for (int i = 0; i < N; i++) exp_img[3*i +: 3] = {b[i], m_lat[i], m_pwr[i]};
    @(negedge clk);
    scan_capture_i = 1'b1;
    @(negedge clk);
    scan_capture_i = 1'b0; scan_shift_i = 1'b1; scan_in_i = 1'b1;
    bad = 0;
    for (int k = 0; k < 3*N; k++) begin
      got[k] = scan_out_o;
      @(negedge clk);
    end
    scan_shift_i = 1'b0;
    chk(got == exp_img, req, "scan image", 64'(got), 64'(exp_img));
    chk(scan_out_o == 1'b1, req, "scan_in reaches bit0", 64'(scan_out_o), 64'd1);
    scan_in_i = 1'b0;
  endtask

  task automatic readout(input string req, input bit restart);
    logic [N-1:0] b;
    int nvalid;
    int bad_sel;
    int bad_word;
    b = m_byp();
    nvalid = 0; bad_sel = 0; bad_word = 0;
    @(negedge clk);
    rd_start_i = 1'b1;
    @(negedge clk);
    rd_start_i = 1'b0;
    for (int j = 0; j < N*SL; j++) begin
      int s;
      logic [N-1:0] exp_sel;
      logic [DW-1:0] exp_w;
      s = j / SL;
      exp_sel = b[s] ? '0 : (N'(1) << s);
      if (rd_sel_o != exp_sel) begin
        bad_sel++;
        chk(1'b0, req, "rd_sel_o", 64'(rd_sel_o), 64'(exp_sel));
      end
      if ((j % SL) == SL-1) begin
        exp_w = b[s] ? FILL : chan_word(s);
        if (!rd_valid_o || rd_slot_o != CHW'(s) || rd_data_o != exp_w) begin
          bad_word++;
          chk(1'b0, req, "slot word", {32'(rd_slot_o), 16'(rd_valid_o), 16'(rd_data_o)},
              {32'(s), 16'd1, 16'(exp_w)});
        end
        nvalid++;
      end else if (rd_valid_o) begin
        bad_word++;
        chk(1'b0, req, "valid mid-slot", 64'(j), 64'(SL-1));
      end
      rd_start_i = (restart && j == 5);
      @(negedge clk);
    end
    rd_start_i = 1'b0;
    chk(bad_sel == 0 && bad_word == 0, req, "run slots, order and words",
        64'(bad_sel + bad_word), 64'd0);
    chk(!rd_valid_o && rd_sel_o == '0, req, "run ends after last slot",
        64'(rd_valid_o), 64'd0);
  endtask

  task automatic raise_latch(input int c, input string req);
    logic was_on;
    was_on = m_pwr[c];
    @(negedge clk);
    latchup_i[c] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(pwr_en_o[c] == was_on, req, "power held for two edges", 64'(pwr_en_o[c]), 64'(was_on));
    @(negedge clk);
    m_pwr[c] = 1'b0; m_lat[c] = 1'b1;
    check_state(req);
  endtask

  task automatic drop_latch(input int c);
    latchup_i[c] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_pwr = '0; m_lat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check_state("R1");
    chk(rd_sel_o == '0 && !rd_valid_o, "R1", "readout idle", 64'(rd_valid_o), 64'd0);
    chk(scan_out_o == 1'b0, "R1", "scan_out", 64'(scan_out_o), 64'd0);
    scan_check("R1");

    // R2 sweep: enable every channel one at a time
    for (int c = 0; c < N; c++) begin
      send_cmd(2'b01, c);
      check_state("R2");
    end
    // R2 no-effect ops
    send_cmd(2'b00, 3);
    check_state("R2");
    send_cmd(2'b11, 5);
    check_state("R2");

    // R6 full run, then run with a restart attempt mid-way
    readout("R6", 1'b0);
    readout("R6", 1'b1);

    // R2 disable every third channel
    for (int c = 0; c < N; c += 3) begin
      send_cmd(2'b10, c);
      check_state("R2");
    end
    // R7 run with powered-off channels
    readout("R7", 1'b0);
    scan_check("R8");

    // R3 sweep: fault each channel in turn, then clear it again
    for (int c = 0; c < N; c++) begin
      logic keep;
      keep = m_pwr[c];
      raise_latch(c, "R3");
      drop_latch(c);
      check_state("R3");
      if (keep) send_cmd(2'b01, c);
      else begin
        send_cmd(2'b01, c);
        send_cmd(2'b10, c);
      end
      check_state("R4");
    end

    // R4 enable while flag held: stays latched
    raise_latch(7, "R3");
    send_cmd(2'b01, 7);
    check_state("R4");
    drop_latch(7);
    raise_latch(2, "R3");
    drop_latch(2);
    send_cmd(2'b10, 2);
    check_state("R4");
    scan_check("R4");

    // R7 run with latched channels, R5 gating
    readout("R7", 1'b0);
    check_state("R5");

    // R4 re-enable clears faults
    send_cmd(2'b01, 2);
    send_cmd(2'b01, 7);
    check_state("R4");
    scan_check("R8");

    for (int c = 0; c < N; c++) send_cmd(2'b01, c);
    readout("R6", 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule